// File: doc/BRIEF.md
# Threshold Event Capture with Pretrigger History

This block watches a double-rate sample stream made of two interleaved 8-bit lanes. The first lane is sampled on the rising edge of the system clock and the second on the falling edge, so every clock cycle carries one pair of samples: the rising-edge sample first, then the falling-edge sample. Each pair is compared against a threshold that may be changed on any cycle. When a pair crosses the threshold, the block writes one event into an output queue. The event holds a header with the time value seen at the crossing and a flag for the lane that crossed first. The header is followed by a window of sample pairs that begins some pairs before the crossing.

A crossing that arrives while an event is still being written stretches that event instead of starting a second one. An event becomes visible to the downstream reader only once its last word is in the queue. If the queue runs out of room part way through, the whole event is discarded. A sticky overflow flag and a drop counter then record the loss. A packet builder drains the queue through a simple read strobe with look-ahead data.

Top module: `pulse_capture`

## Requirements
- R1: Every cycle carries one pair. A sample word has bit 17 = 0, bit 16 = 0, bits 15:8 = rising-lane sample and bits 7:0 = falling-lane sample.
- R2: A pair crosses when either of its samples is greater than or equal to `thresh_i`, compared unsigned. The threshold is taken from the same cycle as the pair, so a change applies at once.
- R3: Each event starts with a header word: bit 17 = 1, bits 16:1 = `time_i` in the cycle of the first crossing, bit 0 = 0 if the rising-lane sample crossed and 1 if only the falling-lane sample crossed.
- R4: After the header come PRE pairs from before the crossing pair, then the crossing pair, then POST pairs after it, all in arrival order. Pairs from before reset read as zero.
- R5: A crossing on any pair that arrives while the event is still being written extends the event. This covers every pair up to PRE+1 pairs after the current last window pair. The event then ends POST pairs after the latest crossing, with no second header.
- R6: `rd_empty_o` stays high until the last word of an event is written. For a crossing in cycle t with no extension, the event becomes readable after the clock edge of cycle t+PRE+POST+1.
- R7: If the queue cannot take every word of an event, no word of it is ever readable. `ovf_o` is then set and stays set until reset, and `drop_cnt_o` increments once.
- R8: After reset the queue is empty, `ovf_o` is 0, `drop_cnt_o` is 0 and the pretrigger history holds zeros.
- R9: While not empty, `rd_data_o` shows the oldest word, and `rd_en_i` removes it at the clock edge. `rd_en_i` while empty has no effect.
- R10: Pairs that do not cross, outside any event window, write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rise_smp_i | input | 8 | Sample taken on the rising clock edge |
| fall_smp_i | input | 8 | Sample taken on the falling clock edge |
| thresh_i | input | 8 | Trigger threshold |
| time_i | input | 16 | Free-running time value |
| rd_en_i | input | 1 | Pop the oldest queue word |
| rd_data_o | output | 18 | Oldest queue word |
| rd_empty_o | output | 1 | No committed word available |
| ovf_o | output | 1 | Sticky: an event was discarded |
| drop_cnt_o | output | 8 | Number of discarded events |

## Verification
A delay line that is off by one stage shows up in the first event read out. The words in the pretrigger slots shift by one pair, and the crossing pair no longer sits at word PRE+1. A window counter or extension fault changes the number of words between headers. This shows at the end of any event with a second crossing, including one that lands on the last write cycle. A fault in the commit or rewind pointers shows as `rd_empty_o` dropping a cycle early or late against the exact cycle in R6. It also shows as fragments of a discarded event appearing in the readout after an overflow.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_CAPT = 1'b1} cap_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/trig_detect.sv
module trig_detect #(
  parameter int SMP_W = 8
) (
  input  logic [SMP_W-1:0] rise_i,
  input  logic [SMP_W-1:0] fall_i,
  input  logic [SMP_W-1:0] thr_i,
  output logic             hit_o,
  output logic             lane_o
);
  logic r_hit, f_hit;
  assign r_hit  = (rise_i >= thr_i);
  assign f_hit  = (fall_i >= thr_i);
  assign hit_o  = r_hit | f_hit;
  // 0: rising lane crossed (earlier in time), 1: only falling lane
  assign lane_o = ~r_hit;
endmodule

// File: rtl/delay_line.sv
module delay_line #(
  parameter int W      = 16,
  parameter int STAGES = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= g_stg[g-1].q;
      end
    end
  end
  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/commit_fifo.sv
module commit_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         commit_i,
  input  logic         rewind_i,
  output logic         full_o,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  spec_q, cmt_q, rd_q, spec_nx;
  logic [AW:0]  spec_occ, cmt_occ;

  assign spec_occ  = spec_q - rd_q;
  assign cmt_occ   = cmt_q - rd_q;
  assign full_o    = (spec_occ == DEPTH_P);
  assign empty_o   = (cmt_q == rd_q);
  assign rd_data_o = mem_q[rd_q[AW-1:0]];
  assign spec_nx   = spec_q + (AW+1)'(wr_i);

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[spec_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q <= '0;
      cmt_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (rewind_i)      spec_q <= cmt_q;
      else               spec_q <= spec_nx;
      if (commit_i)      cmt_q  <= spec_nx;
      if (rd_i && !empty_o) rd_q <= rd_q + 1'b1;
    end
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o); // R7
  AST_OCC_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_occ <= spec_occ) && (spec_occ <= DEPTH_P)); // R6
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o) |=> $stable(rd_q)); // R9
endmodule

// File: rtl/pulse_capture.sv
module pulse_capture
  import cap_pkg::*;
#(
  parameter int SMP_W      = 8,
  parameter int TIME_W     = 16,
  parameter int PRE        = 4,
  parameter int POST       = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int DROP_W     = 8,
  localparam int WORD_W    = 1 + max_u(TIME_W + 1, 2 * SMP_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SMP_W-1:0]  rise_smp_i,
  input  logic [SMP_W-1:0]  fall_smp_i,
  input  logic [SMP_W-1:0]  thresh_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_empty_o,
  output logic              ovf_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int PAIR_W = 2 * SMP_W;
  localparam int WIN    = PRE + 1 + POST;
  localparam int CNT_W  = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN);

  logic              hit, lane;
  logic [PAIR_W-1:0] dly_pair;
  logic              fifo_full, fifo_empty;
  logic              wr, commit, rewind;
  logic [WORD_W-1:0] wdata, hdr_word, smp_word;

  cap_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              drop_q, drop_d;
  logic              ovf_q;
  logic [DROP_W-1:0] drop_cnt_q;

  trig_detect #(.SMP_W(SMP_W)) u_trig (
    .rise_i (rise_smp_i),
    .fall_i (fall_smp_i),
    .thr_i  (thresh_i),
    .hit_o  (hit),
    .lane_o (lane)
  );

  // PRE+1 stages: the header cycle lets the delayed stream start PRE pairs back
  delay_line #(.W(PAIR_W), .STAGES(PRE + 1)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rise_smp_i, fall_smp_i}),
    .q_o    (dly_pair)
  );

  commit_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_data_i (wdata),
    .commit_i  (commit),
    .rewind_i  (rewind),
    .full_o    (fifo_full),
    .rd_i      (rd_en_i),
    .rd_data_o (rd_data_o),
    .empty_o   (fifo_empty)
  );

  always_comb begin
    hdr_word                = '0;
    hdr_word[WORD_W-1]      = 1'b1;
    hdr_word[TIME_W:0]      = {time_i, lane};
    smp_word                = '0;
    smp_word[PAIR_W-1:0]    = dly_pair;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    drop_d  = drop_q;
    wr      = 1'b0;
    commit  = 1'b0;
    rewind  = 1'b0;
    wdata   = smp_word;
    unique case (state_q)
      ST_IDLE: begin
        wdata = hdr_word;
        if (hit) begin
          state_d = ST_CAPT;
          cnt_d   = WIN_C;
          if (fifo_full) drop_d = 1'b1;
          else           wr     = 1'b1;
        end
      end
      ST_CAPT: begin
        if (!drop_q) begin
          if (fifo_full) drop_d = 1'b1;
          else           wr     = 1'b1;
        end
        cnt_d = hit ? WIN_C : cnt_q - 1'b1;
        if (cnt_d == '0) begin
          state_d = ST_IDLE;
          drop_d  = 1'b0;
          if (drop_q || (!drop_q && fifo_full)) rewind = 1'b1;
          else                                  commit = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      drop_q     <= 1'b0;
      ovf_q      <= 1'b0;
      drop_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drop_q  <= drop_d;
      if (rewind) begin
        ovf_q      <= 1'b1;
        drop_cnt_q <= drop_cnt_q + 1'b1;
      end
    end
  end

  assign rd_empty_o = fifo_empty;
  assign ovf_o      = ovf_q;
  assign drop_cnt_o = drop_cnt_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drop_cnt_q) |-> ovf_q); // R7
  AST_EMPTY_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && hit && fifo_empty) |=> fifo_empty); // R6
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= WIN_C); // R5
  AST_IDLE_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !drop_q); // R7
endmodule

// File: tb/pulse_capture_test.sv
`timescale 1ns/1ps
module pulse_capture_test;
  localparam int PRE = 4, POST = 8, DEPTH = 32;
  localparam int EVLEN = 2 + PRE + POST;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [7:0]  rise_smp_i = '0, fall_smp_i = '0, thresh_i = 8'd255;
  logic [15:0] time_i = '0;
  logic        rd_en_i = 1'b0;
  logic [17:0] rd_data_o;
  logic        rd_empty_o, ovf_o;
  logic [7:0]  drop_cnt_o;

  always #2 clk = ~clk;

  pulse_capture #(.PRE(PRE), .POST(POST), .FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rise_smp_i(rise_smp_i), .fall_smp_i(fall_smp_i),
    .thresh_i(thresh_i), .time_i(time_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .rd_empty_o(rd_empty_o), .ovf_o(ovf_o), .drop_cnt_o(drop_cnt_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // {exp_trig, exp_lane, thr, rise, fall}
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 1'b0, 8'd80,  8'd79,  8'd79},
    {1'b1, 1'b0, 8'd80,  8'd80,  8'd0},
    {1'b1, 1'b1, 8'd80,  8'd0,   8'd80},
    {1'b1, 1'b0, 8'd80,  8'd200, 8'd200},
    {1'b0, 1'b0, 8'd255, 8'd254, 8'd254},
    {1'b1, 1'b1, 8'd1,   8'd0,   8'd1},
    {1'b1, 1'b1, 8'd128, 8'd127, 8'd129},
    {1'b1, 1'b0, 8'd200, 8'd255, 8'd10}
  };

  logic [7:0]  s_r [256], s_f [256], s_thr [256];
  logic [15:0] s_tm [256];
  logic        emp_after [256];
  logic [17:0] exp_w [256], rd_w [256];
  int exp_n, rd_n, exp_drops;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; rd_en_i = 1'b0;
    rise_smp_i = '0; fall_smp_i = '0; thresh_i = 8'd255;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic drive_raw(input logic [7:0] r, input logic [7:0] f, input logic [7:0] t);
    @(negedge clk);
    rise_smp_i = r; fall_smp_i = f; thresh_i = t;
    @(posedge clk);
  endtask

  task automatic drain();
    rd_n = 0;
    @(negedge clk);
    while (!rd_empty_o && rd_n < 256) begin
      rd_w[rd_n] = rd_data_o;
      rd_n++;
      rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
    end
  endtask

  function automatic bit crosses(input int k);
    return (s_r[k] >= s_thr[k]) || (s_f[k] >= s_thr[k]);
  endfunction
  function automatic logic [15:0] pair_at(input int p);
    return (p < 0) ? 16'h0 : {s_r[p], s_f[p]};
  endfunction

  task automatic init_stim(input int n, input logic [7:0] thr);
    for (int k = 0; k < n; k++) begin
      s_r[k] = 8'((k * 7) % 60); s_f[k] = 8'((k * 7 + 3) % 60);
      s_thr[k] = thr; s_tm[k] = 16'(k * 3 + 100);
    end
  endtask

  task automatic play(input int n);
    do_reset();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0) emp_after[k-1] = rd_empty_o;
      rise_smp_i = s_r[k]; fall_smp_i = s_f[k]; thresh_i = s_thr[k]; time_i = s_tm[k];
      @(posedge clk);
    end
    @(negedge clk);
    emp_after[n-1] = rd_empty_o;
  endtask

  // Expected events from R3,R4,R5,R7 assuming no reads during the run
  task automatic build_model(input int n);
    int k, t0, last, j, occ, len;
    exp_n = 0; exp_drops = 0; occ = 0; k = 0;
    while (k < n) begin
      if (crosses(k)) begin
        t0 = k; last = k + POST; j = k + 1;
        while (j < n && j <= last + PRE + 1) begin
          if (crosses(j)) last = j + POST;
          j++;
        end
        len = 2 + last - (t0 - PRE);
        if (occ + len <= DEPTH) begin
          exp_w[exp_n] = {1'b1, s_tm[t0], (s_r[t0] >= s_thr[t0]) ? 1'b0 : 1'b1};
          exp_n++;
          for (int p = t0 - PRE; p <= last; p++) begin
            exp_w[exp_n] = {2'b00, pair_at(p)};
            exp_n++;
          end
          occ += len;
        end else exp_drops++;
        k = last + PRE + 2;
      end else k++;
    end
  endtask

  task automatic compare_all(input string req);
    check({req, " word count"}, rd_n, exp_n);
    for (int i = 0; i < exp_n && i < rd_n; i++) check(req, rd_w[i], exp_w[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    do_reset();
    @(negedge clk);
    check("R8 empty after reset", rd_empty_o, 1);
    check("R8 ovf after reset", ovf_o, 0);
    check("R8 drop count after reset", drop_cnt_o, 0);

    // Table walk: R2 compare, R3 lane flag, R10 no-trigger
    for (int v = 0; v < 8; v++) begin
      logic [7:0] thr, r, f;
      logic et, el;
      {et, el, thr, r, f} = VEC[v];
      repeat (PRE + 2) drive_raw(8'd0, 8'd0, thr);
      drive_raw(r, f, thr);
      repeat (PRE + POST + 4) drive_raw(8'd0, 8'd0, thr);
      drain();
      check("R2/R10 event word count", rd_n, et ? EVLEN : 0);
      if (et && rd_n == EVLEN) begin
        check("R3 header flag", rd_w[0][17], 1);
        check("R3 lane bit", rd_w[0][0], el);
        check("R1 crossing pair word", rd_w[PRE + 1], {2'b00, r, f});
      end
    end

    // R9: read while empty is ignored; R1 R3 R4 R6 with a ramp
    do_reset();
    @(negedge clk); rd_en_i = 1'b1; @(negedge clk); rd_en_i = 1'b0;
    init_stim(60, 8'd250);
    s_r[20] = 8'd250;
    play(60);
    check("R6 empty before last write", emp_after[20 + PRE + POST], 1);
    check("R6 readable after last write", emp_after[20 + PRE + POST + 1], 0);
    drain();
    build_model(60);
    compare_all("R4 pretrigger window and timestamp");
    check("R9 first word is header after empty read", rd_w[0][17], 1);
    check("R9 empty after drain", rd_empty_o, 1);

    // R5 extension, including crossing on the final write cycle
    init_stim(80, 8'd250);
    s_f[20] = 8'd251;
    s_r[20 + POST + PRE + 1] = 8'd252;
    play(80);
    drain();
    build_model(80);
    compare_all("R5 extended window");
    check("R5 single event length", rd_n, 2 + (20 + POST + PRE + 1 + POST) - (20 - PRE));

    // R2 threshold changed between two identical pairs
    init_stim(60, 8'd150);
    s_r[15] = 8'd100; s_f[15] = 8'd100;
    s_r[16] = 8'd100; s_f[16] = 8'd100; s_thr[16] = 8'd90;
    play(60);
    drain();
    build_model(60);
    compare_all("R2 runtime threshold");
    check("R2 header time from second pair", rd_w[0][16:1], s_tm[16]);

    // R7 overflow: two events fit, the next two are discarded whole
    init_stim(100, 8'd250);
    s_r[10] = 8'd255; s_r[30] = 8'd255; s_f[50] = 8'd255; s_r[70] = 8'd255;
    play(100);
    check("R7 ovf set", ovf_o, 1);
    check("R7 drop count", drop_cnt_o, 2);
    drain();
    build_model(100);
    check("R7 model drops", exp_drops, 2);
    compare_all("R7 kept events only");
    check("R7 ovf sticky after drain", ovf_o, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule